// File: doc/BRIEF.md
# Three-Channel Timebase Event Unit

This block watches a 32-bit timebase taken from a real-time counter: whole seconds in the upper half (bits 31:16) and binary fractions of a second in the lower half (bits 15:0), so 0x0005_8000 is 5.5 seconds. It has three event channels. Each one holds a target in that same format. A channel fires when the timebase has reached or passed its target. The test uses a sliding window one second wide. As a result, writing a target anywhere from one second in the past up to the present time gives an event at once.

Channel 0 only compares. Channel 1 either compares or captures: in capture mode it records the timebase on a rising edge of an external input. Channel 2 compares and, in continuous mode, moves its own target forward by a programmable step each time it fires. This gives a periodic wake-up.

Every channel event sets a sticky flag that is cleared by writing 1. The event also starts a shared delay, counted in low-frequency ticks, after which a one-clock delayed pulse leaves the block. A mask picks which delayed pulses are ORed into one combined output. Software uses a flat word-addressed register port. The low-frequency tick arrives as a one-clock strobe in the single fast clock domain.

Top module: `rtc_chan_evt`

## Requirements
- R1: After reset every register reads zero and all event outputs are low.
- R2: An enabled compare channel that is armed fires when (timebase − target) mod 2^32 is below 0x10000 (one second). It sets its flag on the next clock. Both exactly reaching the target and jumping past it count.
- R3: A write to a channel's target arms that channel, and so does the timebase lying outside the channel's window. Firing disarms the channel, so a channel fires once per approach and does not fire again while the timebase stays inside the window.
- R4: A disabled channel never sets its flag. It keeps its armed state, so enabling it while its window holds fires it.
- R5: The flags of channels 0, 1 and 2 read at bits 0, 8 and 16 of address 2. Writing 1 to a flag bit clears it and writing 0 leaves it alone. An event in the same cycle as a clear leaves the flag set.
- R6: With channel 1 in capture mode, its compare path is off. Each rising edge of capture_i stores the timebase in the capture register and sets flag 1. A level held high does not capture again, and nothing is captured while channel 1 is disabled.
- R7: With channel 2 in continuous mode, each channel 2 compare event adds the step register to its target. Without continuous mode the target is left unchanged.
- R8: The delay field, config bits 3:0, sets the delay D. With D = 0, the delayed pulse of a channel comes one clock after its event. With D > 0, it comes on the clock of the D-th tick after the event. Each pulse lasts one clock.
- R9: evt_comb_o is the OR of the delayed pulses whose bits are set in the mask, config bits 6:4 (bit 4 = channel 0).
- R10: The word addresses are: 0 config, 1 control, 2 flags, 3 to 5 the targets of channels 0 to 2, 6 step, 7 capture (read-only). The control bits are: 0 enable ch0, 8 enable ch1, 9 capture mode ch1, 16 enable ch2, 18 continuous ch2. Unused bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Low-frequency tick strobe, one clock wide |
| time_i | input | 32 | Timebase {seconds[15:0], fraction[15:0]} |
| capture_i | input | 1 | Capture request for channel 1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| evt_dly_o | output | 3 | Delayed channel event pulses |
| evt_comb_o | output | 1 | Masked OR of the delayed pulses |

## Verification
The checks assume that time_i changes only between clock edges and holds steady for at least one clock, as a counter that advances on ticks would. They also assume that tick_i and capture_i are already in the clock domain. The bench meets this by driving every input on the falling edge and moving the timebase only together with a tick strobe or while the block is idle. Sweeps stay clear of patterns the requirements leave open: the bench never uses a continuous step small enough to keep channel 2 inside its own window, and it never re-triggers a channel while its delay is pending.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int unsigned NCH     = 3;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned CH_CAP  = 1;
  localparam int unsigned CH_RLD  = 2;

  localparam logic [ADDR_W-1:0] AD_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] AD_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] AD_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] AD_CMP0 = 3'd3;
  localparam logic [ADDR_W-1:0] AD_STEP = 3'd6;
  localparam logic [ADDR_W-1:0] AD_CAPT = 3'd7;

  localparam int unsigned CB_EN0  = 0;
  localparam int unsigned CB_EN1  = 8;
  localparam int unsigned CB_CAP1 = 9;
  localparam int unsigned CB_EN2  = 16;
  localparam int unsigned CB_CNT2 = 18;

  function automatic int unsigned flag_bit(input int unsigned ch);
    return 8 * ch;
  endfunction
endpackage

// File: rtl/rtc_evt_match.sv
module rtc_evt_match #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WIN_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] time_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          en_i,
  input  logic          arm_set_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] WIN = DW'(1) << WIN_W;

  logic [DW-1:0] diff;
  logic          in_win, arm_q;

  assign diff   = time_i - cmp_i;
  assign in_win = diff < WIN;
  assign hit_o  = en_i & arm_q & in_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        arm_q <= 1'b0;
    else if (arm_set_i) arm_q <= 1'b1;
    else if (hit_o)     arm_q <= 1'b0;
    else if (!in_win)   arm_q <= 1'b1;
  end
endmodule

// File: rtl/rtc_evt_delay.sv
module rtc_evt_delay #(
  parameter int unsigned DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             trig_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             pulse_o
);
  logic             pend_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (trig_i) begin
        if (dly_i == '0) begin
          pulse_o <= 1'b1;
          pend_q  <= 1'b0;
        end else begin
          pend_q <= 1'b1;
          cnt_q  <= dly_i;
        end
      end else if (pend_q && tick_i) begin
        if (cnt_q == DLY_W'(1)) begin
          pulse_o <= 1'b1;
          pend_q  <= 1'b0;
        end else begin
          cnt_q <= cnt_q - DLY_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rtc_chan_evt.sv
module rtc_chan_evt
  import rtc_evt_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned DLY_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [DW-1:0]     time_i,
  input  logic              capture_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic [NCH-1:0]    evt_dly_o,
  output logic              evt_comb_o
);
  localparam int unsigned MSK_LSB = DLY_W;

  logic [DLY_W-1:0]        dly_q;
  logic [NCH-1:0]          mask_q, en_q, flag_q;
  logic                    capm_q, cont_q, cap_prev_q;
  logic [NCH-1:0][DW-1:0]  cmp_q;
  logic [DW-1:0]           step_q, capt_q;

  logic [NCH-1:0] cmp_wr, hit_cmp, ch_evt, flag_clr, arm_set, ch_en;
  logic           flag_wr, cap_hit;

  assign flag_wr = reg_we_i && (reg_addr_i == AD_FLAG);
  assign cap_hit = en_q[CH_CAP] & capm_q & capture_i & ~cap_prev_q;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      cmp_wr[i]   = reg_we_i && (reg_addr_i == AD_CMP0 + ADDR_W'(i));
      flag_clr[i] = flag_wr && reg_wdata_i[flag_bit(i)];
      ch_en[i]    = en_q[i] && !(i == CH_CAP && capm_q);
      arm_set[i]  = cmp_wr[i] || (i == CH_RLD && hit_cmp[i] && cont_q);
      ch_evt[i]   = hit_cmp[i] || (i == CH_CAP && cap_hit);
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rtc_evt_match #(.DW(DW), .WIN_W(WIN_W)) u_match (
      .clk_i, .rst_ni, .time_i,
      .cmp_i(cmp_q[g]), .en_i(ch_en[g]), .arm_set_i(arm_set[g]), .hit_o(hit_cmp[g])
    );
    rtc_evt_delay #(.DLY_W(DLY_W)) u_delay (
      .clk_i, .rst_ni, .tick_i,
      .trig_i(ch_evt[g]), .dly_i(dly_q), .pulse_o(evt_dly_o[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0; mask_q <= '0; en_q <= '0; capm_q <= 1'b0; cont_q <= 1'b0;
      flag_q <= '0; cmp_q <= '0; step_q <= '0; capt_q <= '0; cap_prev_q <= 1'b0;
    end else begin
      cap_prev_q <= capture_i;
      flag_q     <= (flag_q & ~flag_clr) | ch_evt;
      if (cap_hit) capt_q <= time_i;
      if (reg_we_i && reg_addr_i == AD_CFG) begin
        dly_q  <= reg_wdata_i[DLY_W-1:0];
        mask_q <= reg_wdata_i[MSK_LSB +: NCH];
      end
      if (reg_we_i && reg_addr_i == AD_CTRL) begin
        en_q   <= {reg_wdata_i[CB_EN2], reg_wdata_i[CB_EN1], reg_wdata_i[CB_EN0]};
        capm_q <= reg_wdata_i[CB_CAP1];
        cont_q <= reg_wdata_i[CB_CNT2];
      end
      if (reg_we_i && reg_addr_i == AD_STEP) step_q <= reg_wdata_i;
      for (int i = 0; i < NCH; i++) begin
        if (cmp_wr[i])                                     cmp_q[i] <= reg_wdata_i;
        else if (i == CH_RLD && hit_cmp[i] && cont_q)      cmp_q[i] <= cmp_q[i] + step_q;
      end
    end
  end

  assign evt_comb_o = |(evt_dly_o & mask_q);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AD_CFG: begin
        reg_rdata_o[DLY_W-1:0]       = dly_q;
        reg_rdata_o[MSK_LSB +: NCH]  = mask_q;
      end
      AD_CTRL: begin
        reg_rdata_o[CB_EN0]  = en_q[0];
        reg_rdata_o[CB_EN1]  = en_q[1];
        reg_rdata_o[CB_CAP1] = capm_q;
        reg_rdata_o[CB_EN2]  = en_q[2];
        reg_rdata_o[CB_CNT2] = cont_q;
      end
      AD_FLAG: for (int i = 0; i < NCH; i++) reg_rdata_o[flag_bit(i)] = flag_q[i];
      AD_STEP: reg_rdata_o = step_q;
      AD_CAPT: reg_rdata_o = capt_q;
      default: reg_rdata_o = cmp_q[reg_addr_i - AD_CMP0];
    endcase
  end
endmodule

// File: rtl/rtc_chan_evt_chk.sv
module rtc_chan_evt_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned WIN_W = 16,
  parameter int unsigned NCH   = 3
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [DW-1:0]          time_i,
  input logic                   capture_i,
  input logic [NCH-1:0]         evt_dly_o,
  input logic                   evt_comb_o,
  input logic [NCH-1:0]         en_q,
  input logic                   capm_q,
  input logic                   cont_q,
  input logic [NCH-1:0]         flag_q,
  input logic [NCH-1:0][DW-1:0] cmp_q,
  input logic [DW-1:0]          step_q,
  input logic [DW-1:0]          capt_q,
  input logic                   cap_prev_q,
  input logic [NCH-1:0]         hit_cmp,
  input logic [NCH-1:0]         ch_evt,
  input logic [NCH-1:0]         cmp_wr,
  input logic [NCH-1:0]         flag_clr
);
  localparam logic [DW-1:0] WIN = DW'(1) << WIN_W;

  for (genvar g = 0; g < NCH; g++) begin : g_ast
    AST_HIT_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_cmp[g] |-> ((time_i - cmp_q[g]) < WIN)); // R2
    AST_EVENT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ch_evt[g] |=> flag_q[g]); // R2
    AST_DISABLED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_q[g] && !flag_clr[g]) |=> (flag_q[g] == $past(flag_q[g]))); // R4
    AST_CLEAR_ON_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_clr[g] && !ch_evt[g]) |=> !flag_q[g]); // R5
  end

  AST_CAPTURE_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q[1] && capm_q && capture_i && !cap_prev_q) |=> (capt_q == $past(time_i))); // R6
  AST_RELOAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_cmp[2] && cont_q && !cmp_wr[2]) |=> (cmp_q[2] == $past(cmp_q[2] + step_q))); // R7
  AST_COMB_NEEDS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_comb_o |-> (|evt_dly_o)); // R9
endmodule

bind rtc_chan_evt rtc_chan_evt_chk #(.DW(DW), .WIN_W(WIN_W), .NCH(rtc_evt_pkg::NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .time_i(time_i), .capture_i(capture_i),
  .evt_dly_o(evt_dly_o), .evt_comb_o(evt_comb_o), .en_q(en_q), .capm_q(capm_q),
  .cont_q(cont_q), .flag_q(flag_q), .cmp_q(cmp_q), .step_q(step_q), .capt_q(capt_q),
  .cap_prev_q(cap_prev_q), .hit_cmp(hit_cmp), .ch_evt(ch_evt), .cmp_wr(cmp_wr),
  .flag_clr(flag_clr)
);

// File: tb/rtc_chan_evt_bench.sv
module rtc_chan_evt_bench;
  logic        clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, capture_i = 1'b0;
  logic [31:0] time_i = '0, reg_wdata_i = '0, reg_rdata_o;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [2:0]  evt_dly_o;
  logic        evt_comb_o;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  rtc_chan_evt u_rtc_chan_evt (
    .clk_i(clk), .rst_ni, .tick_i, .time_i, .capture_i, .reg_we_i, .reg_addr_i,
    .reg_wdata_i, .reg_rdata_o, .evt_dly_o, .evt_comb_o
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // all tasks are entered and left at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic tick_to(input logic [31:0] t);
    time_i = t; tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, base, d, cmp;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reg reset", v, 32'h0);
    end
    chk("R1 outputs reset", {28'h0, evt_comb_o, evt_dly_o}, 32'h0);

    // R10 register map and unused bits
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R10 cfg readback", v, 32'h0000_007F);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, v); chk("R10 ctrl readback", v, 32'h0005_0301);
    wr(3'd6, 32'hA5A5_1234); rd(3'd6, v); chk("R10 step readback", v, 32'hA5A5_1234);
    wr(3'd4, 32'h0BAD_F00D); rd(3'd4, v); chk("R10 cmp1 readback", v, 32'h0BAD_F00D);
    wr(3'd7, 32'hDEAD_BEEF); rd(3'd7, v); chk("R10 capture read-only", v, 32'h0);
    wr(3'd1, 32'h0); wr(3'd0, 32'h0);

    // R2 window sweep on channel 0
    base = 32'h0050_0000;
    tick_to(base);
    wr(3'd1, 32'h1);
    for (int k = 0; k < 45; k++) begin
      if (k < 40) d = 32'(k * 32'h0800) - 32'h1000;
      else case (k)
        40: d = 32'hFFFF_FFFF;
        41: d = 32'h0;
        42: d = 32'h0000_FFFF;
        43: d = 32'h0001_0000;
        default: d = 32'h0000_0001;
      endcase
      cmp = base - d;
      wr(3'd3, cmp);
      @(negedge clk);
      rd(3'd2, v);
      chk("R2 window", {31'h0, v[0]}, {31'h0, (d < 32'h0001_0000)});
      wr(3'd2, 32'h1);
    end

    // R2/R3 reach by ticks, single fire, then pass over
    base = 32'h0060_0000;
    tick_to(base);
    wr(3'd2, 32'h1);
    wr(3'd3, base + 5);
    for (int k = 1; k <= 8; k++) begin
      tick_to(base + 32'(k));
      rd(3'd2, v);
      chk("R2 reach on tick", {31'h0, v[0]}, {31'h0, (k >= 5)});
    end
    wr(3'd2, 32'h1);
    tick_to(base + 9);
    rd(3'd2, v); chk("R3 no refire in window", {31'h0, v[0]}, 32'h0);
    wr(3'd3, base + 12);
    tick_to(base + 11);
    rd(3'd2, v); chk("R3 armed not yet", {31'h0, v[0]}, 32'h0);
    tick_to(base + 14);
    rd(3'd2, v); chk("R2 passed target", {31'h0, v[0]}, 32'h1);

    // R4 disabled channel
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h1);
    wr(3'd3, base + 14);
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R4 disabled no flag", {31'h0, v[0]}, 32'h0);
    chk("R4 disabled no pulse", {29'h0, evt_dly_o}, 32'h0);
    wr(3'd1, 32'h1);
    @(negedge clk);
    rd(3'd2, v); chk("R4 enable fires armed", {31'h0, v[0]}, 32'h1);

    // R5 flag positions, write-one-to-clear, set beats clear
    wr(3'd1, 32'h0001_0001);
    wr(3'd5, base + 14);
    @(negedge clk);
    rd(3'd2, v); chk("R5 flags 0 and 16", v, 32'h0001_0001);
    wr(3'd2, 32'hFFFE_FEFE); rd(3'd2, v); chk("R5 zero writes keep", v, 32'h0001_0001);
    wr(3'd2, 32'h0000_0100); rd(3'd2, v); chk("R5 bit8 clear no effect", v, 32'h0001_0001);
    wr(3'd2, 32'h0000_0001); rd(3'd2, v); chk("R5 clear ch0", v, 32'h0001_0000);
    wr(3'd2, 32'h0001_0000); rd(3'd2, v); chk("R5 clear ch2", v, 32'h0);
    wr(3'd3, base + 14);
    wr(3'd2, 32'h0000_0001);
    rd(3'd2, v); chk("R5 set wins over clear", v, 32'h0000_0001);

    // R6 capture mode on channel 1
    wr(3'd1, 32'h0000_0300);
    tick_to(32'h0100_1234);
    wr(3'd2, 32'h0000_0100);
    wr(3'd4, 32'h0100_1234);
    @(negedge clk);
    rd(3'd2, v); chk("R6 compare off in capture", {31'h0, v[8]}, 32'h0);
    capture_i = 1'b1;
    @(negedge clk);
    tick_to(32'h0222_5678);
    capture_i = 1'b0;
    @(negedge clk);
    rd(3'd7, v); chk("R6 captured at rise", v, 32'h0100_1234);
    rd(3'd2, v); chk("R6 capture sets flag", {31'h0, v[8]}, 32'h1);
    capture_i = 1'b1;
    @(negedge clk);
    capture_i = 1'b0;
    rd(3'd7, v); chk("R6 second rise", v, 32'h0222_5678);
    wr(3'd1, 32'h0);
    tick_to(32'h0333_0000);
    capture_i = 1'b1;
    @(negedge clk);
    capture_i = 1'b0;
    rd(3'd7, v); chk("R6 disabled no capture", v, 32'h0222_5678);

    // R7 continuous reload on channel 2
    base = 32'h0200_0000;
    tick_to(base);
    wr(3'd6, 32'h0000_0100);
    wr(3'd1, 32'h0005_0000);
    wr(3'd2, 32'h0001_0000);
    wr(3'd5, base + 32'h100);
    tick_to(base + 32'h80);
    rd(3'd5, v); chk("R7 before reach", v, base + 32'h100);
    tick_to(base + 32'h100);
    rd(3'd5, v); chk("R7 first reload", v, base + 32'h200);
    rd(3'd2, v); chk("R7 flag on reload", {31'h0, v[16]}, 32'h1);
    tick_to(base + 32'h1C0);
    rd(3'd5, v); chk("R7 hold between", v, base + 32'h200);
    tick_to(base + 32'h250);
    rd(3'd5, v); chk("R7 second reload", v, base + 32'h300);
    wr(3'd1, 32'h0001_0000);
    wr(3'd5, base + 32'h250);
    @(negedge clk);
    rd(3'd5, v); chk("R7 no reload without mode", v, base + 32'h250);

    // R8/R9 delay sweep on channel 0
    wr(3'd1, 32'h1);
    for (int dl = 0; dl < 16; dl++) begin
      logic [2:0] m;
      int seen;
      m = dl[0] ? 3'b001 : 3'b110;
      seen = 0;
      wr(3'd0, {25'h0, m, 4'(dl)});
      wr(3'd3, time_i);
      @(negedge clk);
      chk("R8 delay zero pulse", {31'h0, evt_dly_o[0]}, {31'h0, (dl == 0)});
      chk("R9 comb at fire", {31'h0, evt_comb_o}, {31'h0, (dl == 0) && m[0]});
      for (int k = 1; k <= 16; k++) begin
        tick_to(time_i);
        chk("R8 delayed pulse tick", {31'h0, evt_dly_o[0]}, {31'h0, (k == dl)});
        chk("R9 comb mask", {31'h0, evt_comb_o}, {31'h0, (k == dl) && m[0]});
      end
    end

    // R9 exhaustive channel subset x mask
    wr(3'd1, 32'h0001_0101);
    wr(3'd0, 32'h1);
    for (int c = 0; c < 3; c++) wr(3'(3 + c), time_i);
    tick_to(time_i);
    tick_to(time_i);
    for (int s = 0; s < 8; s++) begin
      for (int m = 0; m < 8; m++) begin
        wr(3'd0, {25'h0, 3'(m), 4'd1});
        for (int c = 0; c < 3; c++) if (s[c]) wr(3'(3 + c), time_i);
        @(negedge clk);
        tick_to(time_i);
        chk("R8 simultaneous pulses", {29'h0, evt_dly_o}, 32'(s));
        chk("R9 comb subset", {31'h0, evt_comb_o}, {31'h0, |(3'(s) & 3'(m))});
      end
    end

    finish_run();
  end
endmodule